// File: doc/BRIEF.md
# Coherence Probe Fan-out and Acknowledgement Tracker

This block starts the probe phase of one coherence transaction and follows it to the end. When a transaction is accepted, the block builds a destination bitmask over a flat node space. That space holds every core cluster, then one cache node per accelerator slice, then one directory node per accelerator slice. All core clusters are always targeted. At most one accelerator node is added. Which one is added depends on the probe kind, on two configuration inputs (CPU-only system, accelerator cache without a directory), on a conflict-free flag carried by the request, and on an address bit field that picks the slice. The requester is then removed from the mask. The number of remaining destinations is loaded as the pending acknowledgement count.

The block issues the probe as a one-cycle strobe with the mask, the kind and a return-data bit. Each probe response pulse lowers the count by one. When the count reaches zero, the block raises a completion pulse. A transaction that has no targets sends nothing and still completes. The cycle on which the probe was issued and the cycle on which it completed are both captured from a free-running cycle counter. Only one transaction is tracked at a time.

Top module: `probe_fanout_tracker`

## Requirements
- R1: While reset is high and after its release with no stimulus, `probe_valid`, `done`, `err_stray` and `busy` are 0 and `pending_cnt` is 0.
- R2: A start accepted at a clock edge sets `probe_valid` for exactly the following cycle. Every core cluster bit (bits 0 to NUM_CLUSTERS-1) is set in `probe_dest` except the requester's bit. `pending_cnt` equals the number of set bits. A requester ID beyond the node space removes nothing.
- R3: The accelerator slice is `start_addr[LINE_OFF +: SEL_BITS]`. Slice a's cache node is bit NUM_CLUSTERS+a and its directory node is bit NUM_CLUSTERS+2^SEL_BITS+a. If the selected node is the requester, it is removed.
- R4: Kind code 00 (invalidate, data returned) adds no accelerator node when `cfg_cpu_only` or `start_conflict_free` is 1. Otherwise it adds the cache node if `cfg_accel_no_dir` is 1, and the directory node if it is 0.
- R5: Kind code 01 (downgrade, data returned) adds no accelerator node when `cfg_cpu_only` is 1. Otherwise it adds the cache node if `cfg_accel_no_dir` is 1, and the directory node if it is 0. `start_conflict_free` has no effect on this kind.
- R6: Kind code 10 (invalidate, no data) adds the directory node whenever `cfg_accel_no_dir` is 0, even when `cfg_cpu_only` is 1. It adds the cache node when `cfg_accel_no_dir` is 1 and `cfg_cpu_only` is 0. It adds none when both are 1.
- R7: `probe_ret_data` is 1 for kind codes 00 and 01 and 0 for code 10. `probe_kind` repeats the accepted code.
- R8: Each `rsp_valid` pulse while a probe is outstanding lowers `pending_cnt` by one. The pulse that brings it to zero makes `done` high for one cycle, in the cycle after that pulse is sampled, and `busy` falls in that same cycle.
- R9: A start whose mask is empty gives no `probe_valid`. `done` pulses two cycles after the start is sampled.
- R10: An `rsp_valid` pulse sampled while no probe is outstanding leaves `pending_cnt` unchanged (it never wraps below zero) and makes `err_stray` high for the next cycle.
- R11: A start presented while `busy` is 1 is ignored. A start with kind code 11 is ignored.
- R12: `probe_start_time` holds the cycle counter value sampled at the edge that accepted the start. `fwd_time` holds the value sampled at the edge that launched `done`. The counter is 0 at the first edge after reset and advances by one per edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_valid | input | 1 | Request to open a probe transaction |
| start_kind | input | 2 | Probe kind code (00, 01, 10; 11 rejected) |
| start_req_id | input | NODE_W | Requester node index |
| start_addr | input | ADDR_W | Line address; holds the slice select field |
| start_conflict_free | input | 1 | Write-through or atomic marked conflict-free |
| cfg_cpu_only | input | 1 | System has no accelerator caches |
| cfg_accel_no_dir | input | 1 | Accelerator caches have no directory node |
| rsp_valid | input | 1 | One probe response received |
| probe_valid | output | 1 | Probe issue strobe |
| probe_kind | output | 2 | Kind of the issued probe |
| probe_dest | output | NODES | Destination bitmask |
| probe_ret_data | output | 1 | Targets must return data |
| pending_cnt | output | CNT_W | Outstanding acknowledgements |
| busy | output | 1 | A transaction is open |
| done | output | 1 | Completion pulse |
| err_stray | output | 1 | Response arrived with nothing outstanding |
| probe_start_time | output | CYCLE_W | Cycle of probe issue |
| fwd_time | output | CYCLE_W | Cycle of completion |

## Verification
A start driven before edge c appears as `probe_valid` one cycle later. For an empty mask it appears instead as `done` two cycles later. The final response appears as `done` one cycle after it is sampled. A stray response appears as `err_stray` one cycle after it is sampled. The bench drives inputs on falling edges and stamps each expected event with the falling edge on which it must be visible, using its own mirror of the cycle counter. A monitor on the same falling edges pops the expectation queue whenever an output event shows. It reports an event that arrives early, late, unexpected or not at all, and it compares mask, count, kind, return-data bit and both timestamps.

// File: rtl/probe_fanout_pkg.sv
package probe_fanout_pkg;

    typedef enum logic [1:0] {
        PK_INV_DATA  = 2'b00,
        PK_DOWNGRADE = 2'b01,
        PK_INV_PLAIN = 2'b10,
        PK_RESERVED  = 2'b11
    } probe_kind_e;

    typedef enum logic [1:0] {
        TS_IDLE  = 2'b00,
        TS_WAIT  = 2'b01,
        TS_DRAIN = 2'b10
    } track_state_e;

    typedef enum logic [1:0] {
        AT_NONE  = 2'b00,
        AT_CACHE = 2'b01,
        AT_DIR   = 2'b10
    } accel_tgt_e;

    typedef struct packed {
        logic cpu_only;
        logic accel_no_dir;
    } fanout_cfg_t;

    // Which accelerator node, if any, a probe of this kind reaches.
    function automatic accel_tgt_e pick_accel(probe_kind_e kind, logic conflict_free,
                                              fanout_cfg_t cfg);
        accel_tgt_e tgt;
        tgt = AT_NONE;
        unique case (kind)
            PK_INV_DATA: begin
                if (!(cfg.cpu_only || conflict_free))
                    tgt = cfg.accel_no_dir ? AT_CACHE : AT_DIR;
            end
            PK_DOWNGRADE: begin
                if (!cfg.cpu_only)
                    tgt = cfg.accel_no_dir ? AT_CACHE : AT_DIR;
            end
            PK_INV_PLAIN: begin
                if (!cfg.accel_no_dir)
                    tgt = AT_DIR;
                else if (!cfg.cpu_only)
                    tgt = AT_CACHE;
            end
            default: tgt = AT_NONE;
        endcase
        return tgt;
    endfunction

    function automatic logic kind_wants_data(probe_kind_e kind);
        return (kind == PK_INV_DATA) || (kind == PK_DOWNGRADE);
    endfunction

endpackage

// File: rtl/probe_dest_builder.sv
module probe_dest_builder
    import probe_fanout_pkg::*;
#(
    parameter int NUM_CLUSTERS = 4,
    parameter int SEL_BITS     = 2,
    parameter int LINE_OFF     = 6,
    parameter int ADDR_W       = 32,
    parameter int NODES        = NUM_CLUSTERS + 2 * (1 << SEL_BITS),
    parameter int NODE_W       = $clog2(NODES),
    parameter int CNT_W        = $clog2(NODES + 1)
) (
    input  probe_kind_e        kind,
    input  logic [NODE_W-1:0]  req_id,
    input  logic [ADDR_W-1:0]  addr,
    input  logic               conflict_free,
    input  fanout_cfg_t        cfg,
    output logic [NODES-1:0]   dest,
    output logic [CNT_W-1:0]   count
);
    localparam int NUM_ACCEL  = 1 << SEL_BITS;
    localparam int CACHE_BASE = NUM_CLUSTERS;
    localparam int DIR_BASE   = NUM_CLUSTERS + NUM_ACCEL;

    logic [SEL_BITS-1:0] slice;
    accel_tgt_e          tgt;
    logic [NODES-1:0]    want;

    assign slice = addr[LINE_OFF +: SEL_BITS];
    assign tgt   = pick_accel(kind, conflict_free, cfg);

    for (genvar g = 0; g < NODES; g++) begin : g_node
        if (g < CACHE_BASE) begin : g_core
            assign want[g] = 1'b1;
        end else if (g < DIR_BASE) begin : g_cache
            assign want[g] = (tgt == AT_CACHE) && (slice == SEL_BITS'(g - CACHE_BASE));
        end else begin : g_dir
            assign want[g] = (tgt == AT_DIR) && (slice == SEL_BITS'(g - DIR_BASE));
        end
        assign dest[g] = want[g] && (req_id != NODE_W'(g));
    end

    always_comb begin
        count = '0;
        for (int i = 0; i < NODES; i++)
            count = count + CNT_W'(dest[i]);
    end

    always_comb begin
        if (int'(req_id) < NODES)
            a_r2_req_excluded: assert (dest[req_id] == 1'b0);
    end

endmodule

// File: rtl/probe_ack_tracker.sv
module probe_ack_tracker
    import probe_fanout_pkg::*;
#(
    parameter int NODES = 12,
    parameter int CNT_W = $clog2(NODES + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_ok,
    input  probe_kind_e       start_kind,
    input  logic [NODES-1:0]  new_dest,
    input  logic [CNT_W-1:0]  new_count,
    input  logic              rsp_valid,
    output logic              accept,
    output logic              finish,
    output logic              probe_valid,
    output probe_kind_e       probe_kind,
    output logic [NODES-1:0]  probe_dest,
    output logic              probe_ret_data,
    output logic [CNT_W-1:0]  pending,
    output logic              busy,
    output logic              done,
    output logic              err_stray
);
    track_state_e state;
    logic         last_ack;

    assign busy     = (state != TS_IDLE);
    assign accept   = (state == TS_IDLE) && start_ok;
    assign last_ack = (state == TS_WAIT) && rsp_valid && (pending == CNT_W'(1));
    assign finish   = last_ack || (state == TS_DRAIN);

    always_ff @(posedge clk) begin
        if (rst) begin
            state          <= TS_IDLE;
            pending        <= '0;
            probe_valid    <= 1'b0;
            probe_kind     <= PK_INV_DATA;
            probe_dest     <= '0;
            probe_ret_data <= 1'b0;
            done           <= 1'b0;
            err_stray      <= 1'b0;
        end else begin
            probe_valid <= 1'b0;
            done        <= 1'b0;
            err_stray   <= rsp_valid && (state != TS_WAIT);
            unique case (state)
                TS_IDLE: begin
                    if (start_ok) begin
                        pending <= new_count;
                        if (new_count != '0) begin
                            probe_valid    <= 1'b1;
                            probe_kind     <= start_kind;
                            probe_dest     <= new_dest;
                            probe_ret_data <= kind_wants_data(start_kind);
                            state          <= TS_WAIT;
                        end else begin
                            state <= TS_DRAIN;
                        end
                    end
                end
                TS_WAIT: begin
                    if (rsp_valid) begin
                        pending <= pending - CNT_W'(1);
                        if (last_ack) begin
                            done  <= 1'b1;
                            state <= TS_IDLE;
                        end
                    end
                end
                TS_DRAIN: begin
                    done  <= 1'b1;
                    state <= TS_IDLE;
                end
                default: state <= TS_IDLE;
            endcase
        end
    end

    a_r8_count_step: assert property (@(posedge clk) disable iff (rst)
        (state == TS_WAIT && rsp_valid && pending > CNT_W'(1))
            |=> (pending == $past(pending) - CNT_W'(1)) && busy);

    a_r8_done_on_last: assert property (@(posedge clk) disable iff (rst)
        (state == TS_WAIT && rsp_valid && pending == CNT_W'(1)) |=> (done && !busy));

    a_r9_drain_silent: assert property (@(posedge clk) disable iff (rst)
        (state == TS_DRAIN) |=> (done && !probe_valid));

    a_r10_stray_flag: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && state != TS_WAIT) |=> err_stray);

    a_r10_no_wrap: assert property (@(posedge clk) disable iff (rst)
        (state == TS_WAIT) |-> (pending != '0));

    a_r2_mask_matches_count: assert property (@(posedge clk) disable iff (rst)
        probe_valid |-> ($countones(probe_dest) == int'(pending)) && (pending != '0));

    a_r11_no_issue_when_busy: assert property (@(posedge clk) disable iff (rst)
        (busy && !finish) |=> !probe_valid);

endmodule

// File: rtl/probe_time_stamper.sv
module probe_time_stamper #(
    parameter int CYCLE_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               issue_evt,
    input  logic               complete_evt,
    output logic [CYCLE_W-1:0] start_time,
    output logic [CYCLE_W-1:0] finish_time
);
    logic [CYCLE_W-1:0] now;

    always_ff @(posedge clk) begin
        if (rst) begin
            now         <= '0;
            start_time  <= '0;
            finish_time <= '0;
        end else begin
            now <= now + CYCLE_W'(1);
            if (issue_evt)
                start_time <= now;
            if (complete_evt)
                finish_time <= now;
        end
    end

    a_r12_stamp_issue: assert property (@(posedge clk) disable iff (rst)
        issue_evt |=> (start_time == $past(now)));

endmodule

// File: rtl/probe_fanout_tracker.sv
module probe_fanout_tracker
    import probe_fanout_pkg::*;
#(
    parameter int NUM_CLUSTERS = 4,
    parameter int SEL_BITS     = 2,
    parameter int LINE_OFF     = 6,
    parameter int ADDR_W       = 32,
    parameter int CYCLE_W      = 16,
    localparam int NODES       = NUM_CLUSTERS + 2 * (1 << SEL_BITS),
    localparam int NODE_W      = $clog2(NODES),
    localparam int CNT_W       = $clog2(NODES + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start_valid,
    input  logic [1:0]         start_kind,
    input  logic [NODE_W-1:0]  start_req_id,
    input  logic [ADDR_W-1:0]  start_addr,
    input  logic               start_conflict_free,
    input  logic               cfg_cpu_only,
    input  logic               cfg_accel_no_dir,
    input  logic               rsp_valid,
    output logic               probe_valid,
    output logic [1:0]         probe_kind,
    output logic [NODES-1:0]   probe_dest,
    output logic               probe_ret_data,
    output logic [CNT_W-1:0]   pending_cnt,
    output logic               busy,
    output logic               done,
    output logic               err_stray,
    output logic [CYCLE_W-1:0] probe_start_time,
    output logic [CYCLE_W-1:0] fwd_time
);
    probe_kind_e       kind_in;
    probe_kind_e       kind_out;
    fanout_cfg_t       cfg;
    logic [NODES-1:0]  built_dest;
    logic [CNT_W-1:0]  built_count;
    logic              start_ok;
    logic              accept;
    logic              finish;

    assign kind_in          = probe_kind_e'(start_kind);
    assign cfg.cpu_only     = cfg_cpu_only;
    assign cfg.accel_no_dir = cfg_accel_no_dir;
    assign start_ok         = start_valid && (kind_in != PK_RESERVED);
    assign probe_kind       = kind_out;

    probe_dest_builder #(
        .NUM_CLUSTERS (NUM_CLUSTERS),
        .SEL_BITS     (SEL_BITS),
        .LINE_OFF     (LINE_OFF),
        .ADDR_W       (ADDR_W),
        .NODES        (NODES),
        .NODE_W       (NODE_W),
        .CNT_W        (CNT_W)
    ) u_dest (
        .kind          (kind_in),
        .req_id        (start_req_id),
        .addr          (start_addr),
        .conflict_free (start_conflict_free),
        .cfg           (cfg),
        .dest          (built_dest),
        .count         (built_count)
    );

    probe_ack_tracker #(
        .NODES (NODES),
        .CNT_W (CNT_W)
    ) u_track (
        .clk            (clk),
        .rst            (rst),
        .start_ok       (start_ok),
        .start_kind     (kind_in),
        .new_dest       (built_dest),
        .new_count      (built_count),
        .rsp_valid      (rsp_valid),
        .accept         (accept),
        .finish         (finish),
        .probe_valid    (probe_valid),
        .probe_kind     (kind_out),
        .probe_dest     (probe_dest),
        .probe_ret_data (probe_ret_data),
        .pending        (pending_cnt),
        .busy           (busy),
        .done           (done),
        .err_stray      (err_stray)
    );

    probe_time_stamper #(
        .CYCLE_W (CYCLE_W)
    ) u_time (
        .clk          (clk),
        .rst          (rst),
        .issue_evt    (accept),
        .complete_evt (finish),
        .start_time   (probe_start_time),
        .finish_time  (fwd_time)
    );

    a_r11_reserved_ignored: assert property (@(posedge clk) disable iff (rst)
        (!busy && start_valid && start_kind == 2'b11) |=> (!busy && !probe_valid));

endmodule

// File: tb/probe_fanout_tracker_test.sv
module probe_fanout_tracker_test;

    localparam int NC       = 1;
    localparam int SB       = 2;
    localparam int LOFF     = 6;
    localparam int AW       = 32;
    localparam int CW       = 16;
    localparam int NACC     = 1 << SB;
    localparam int NODES    = NC + 2 * NACC;
    localparam int NODE_W   = $clog2(NODES);
    localparam int CNT_W    = $clog2(NODES + 1);

    typedef struct {
        bit          is_done;
        int          due;
        logic [NODES-1:0] dest;
        int          cnt;
        logic [1:0]  kind;
        bit          ret;
        int          stamp;
        string       tag;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start_valid = 1'b0;
    logic [1:0]        start_kind = 2'b00;
    logic [NODE_W-1:0] start_req_id = '0;
    logic [AW-1:0]     start_addr = '0;
    logic              start_conflict_free = 1'b0;
    logic              cfg_cpu_only = 1'b0;
    logic              cfg_accel_no_dir = 1'b0;
    logic              rsp_valid = 1'b0;
    logic              probe_valid;
    logic [1:0]        probe_kind;
    logic [NODES-1:0]  probe_dest;
    logic              probe_ret_data;
    logic [CNT_W-1:0]  pending_cnt;
    logic              busy;
    logic              done;
    logic              err_stray;
    logic [CW-1:0]     probe_start_time;
    logic [CW-1:0]     fwd_time;

    int   n_checks = 0;
    int   n_fails  = 0;
    int   tb_cyc   = 0;
    exp_t sb_q[$];

    always #10 clk = ~clk;

    always @(posedge clk) begin
        if (rst) tb_cyc <= 0;
        else     tb_cyc <= tb_cyc + 1;
    end

    probe_fanout_tracker #(
        .NUM_CLUSTERS (NC),
        .SEL_BITS     (SB),
        .LINE_OFF     (LOFF),
        .ADDR_W       (AW),
        .CYCLE_W      (CW)
    ) uut (
        .clk                 (clk),
        .rst                 (rst),
        .start_valid         (start_valid),
        .start_kind          (start_kind),
        .start_req_id        (start_req_id),
        .start_addr          (start_addr),
        .start_conflict_free (start_conflict_free),
        .cfg_cpu_only        (cfg_cpu_only),
        .cfg_accel_no_dir    (cfg_accel_no_dir),
        .rsp_valid           (rsp_valid),
        .probe_valid         (probe_valid),
        .probe_kind          (probe_kind),
        .probe_dest          (probe_dest),
        .probe_ret_data      (probe_ret_data),
        .pending_cnt         (pending_cnt),
        .busy                (busy),
        .done                (done),
        .err_stray           (err_stray),
        .probe_start_time    (probe_start_time),
        .fwd_time            (fwd_time)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Expected mask from the requirement text (R2..R6).
    function automatic logic [NODES-1:0] exp_mask(input logic [1:0] k, input int req,
                                                 input int slice, input bit cf,
                                                 input bit cpu, input bit nodir);
        logic [NODES-1:0] m;
        int acc;
        m = '0;
        for (int i = 0; i < NC; i++) m[i] = 1'b1;
        acc = -1;
        case (k)
            2'b00: if (!cpu && !cf) acc = nodir ? NC + slice : NC + NACC + slice;
            2'b01: if (!cpu) acc = nodir ? NC + slice : NC + NACC + slice;
            2'b10: begin
                if (!nodir) acc = NC + NACC + slice;
                else if (!cpu) acc = NC + slice;
            end
            default: acc = -1;
        endcase
        if (acc >= 0) m[acc] = 1'b1;
        if (req < NODES) m[req] = 1'b0;
        return m;
    endfunction

    // Scoreboard monitor: every output event must match the queue head on its due cycle.
    always @(negedge clk) begin
        if (!rst) begin
            if (probe_valid || done) begin
                if (sb_q.size() == 0) begin
                    check(1'b0, "R11 unexpected event", {probe_valid, done}, 0);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    check(e.due == tb_cyc, {e.tag, " event cycle"}, tb_cyc, e.due);
                    check(done == e.is_done && probe_valid == !e.is_done,
                          {e.tag, " event type"}, {probe_valid, done}, e.is_done ? 1 : 2);
                    if (!e.is_done) begin
                        check(probe_dest == e.dest, {e.tag, " R2 dest"}, probe_dest, e.dest);
                        check(int'(pending_cnt) == e.cnt, {e.tag, " R2 count"}, pending_cnt, e.cnt);
                        check(probe_kind == e.kind && probe_ret_data == e.ret,
                              {e.tag, " R7 kind/ret"}, {probe_kind, probe_ret_data}, {e.kind, e.ret});
                        check(probe_start_time == CW'(e.stamp), {e.tag, " R12 start time"},
                              probe_start_time, e.stamp);
                    end else begin
                        check(!busy && pending_cnt == 0, {e.tag, " R8 idle at done"}, busy, 0);
                        check(fwd_time == CW'(e.stamp), {e.tag, " R12 fwd time"}, fwd_time, e.stamp);
                    end
                end
            end else if (sb_q.size() > 0 && sb_q[0].due <= tb_cyc) begin
                exp_t e;
                e = sb_q.pop_front();
                check(1'b0, {e.tag, " missing event"}, tb_cyc, e.due);
            end
        end
    end

    task automatic push_done(input int due, input int stamp, input string tag);
        exp_t e;
        e.is_done = 1'b1; e.due = due; e.dest = '0; e.cnt = 0;
        e.kind = 2'b00; e.ret = 1'b0; e.stamp = stamp; e.tag = tag;
        sb_q.push_back(e);
    endtask

    // Driver: open one transaction, answer it fully, return to idle.
    task automatic run_txn(input logic [1:0] k, input int req, input int slice,
                           input bit cf, input bit cpu, input bit nodir, input string tag);
        logic [NODES-1:0] m;
        int cnt;
        int c;
        exp_t e;
        m   = exp_mask(k, req, slice, cf, cpu, nodir);
        cnt = $countones(m);
        @(negedge clk);
        start_valid         = 1'b1;
        start_kind          = k;
        start_req_id        = NODE_W'(req);
        start_addr          = AW'(slice) << LOFF | AW'(32'h1234_0000);
        start_conflict_free = cf;
        cfg_cpu_only        = cpu;
        cfg_accel_no_dir    = nodir;
        c = tb_cyc;
        if (cnt > 0) begin
            e.is_done = 1'b0; e.due = c + 1; e.dest = m; e.cnt = cnt;
            e.kind = k; e.ret = (k != 2'b10); e.stamp = c; e.tag = tag;
            sb_q.push_back(e);
        end else begin
            push_done(c + 2, c + 1, {tag, " R9 zero-target"});
        end
        @(negedge clk);
        start_valid = 1'b0;
        for (int i = 0; i < cnt; i++) begin
            rsp_valid = 1'b1;
            if (i == cnt - 1) push_done(tb_cyc + 1, tb_cyc, {tag, " R8 last ack"});
            @(negedge clk);
            rsp_valid = 1'b0;
            if (i != cnt - 1)
                check(int'(pending_cnt) == cnt - i - 1, {tag, " R8 decrement"},
                      pending_cnt, cnt - i - 1);
        end
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!probe_valid && !done && !err_stray && !busy && pending_cnt == 0,
              "R1 state in reset", {probe_valid, done, err_stray, busy}, 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        check(!probe_valid && !done && !err_stray && !busy && pending_cnt == 0,
              "R1 idle after reset", {probe_valid, done, err_stray, busy}, 0);

        // R2 R3 R4 variants of invalidate-with-data
        run_txn(2'b00, 0, 2, 0, 0, 0, "R4 inv dir node");
        run_txn(2'b00, 3, 3, 0, 0, 1, "R4 inv cache node");
        run_txn(2'b00, 0, 1, 1, 0, 0, "R4 conflict-free none");
        run_txn(2'b00, 6, 0, 0, 1, 0, "R4 cpu-only none");
        // R5 downgrade
        run_txn(2'b01, 0, 2, 0, 1, 1, "R5 cpu-only none");
        run_txn(2'b01, 8, 1, 1, 0, 1, "R5 cache, flag ignored");
        run_txn(2'b01, 0, 0, 0, 0, 0, "R5 dir node");
        // R6 plain invalidate
        run_txn(2'b10, 0, 3, 0, 1, 0, "R6 dir despite cpu-only");
        run_txn(2'b10, 0, 2, 0, 1, 1, "R6 none");
        run_txn(2'b10, 15, 0, 0, 0, 1, "R6 cache, id out of range");
        // R3 requester is the selected accelerator node
        run_txn(2'b00, 6, 1, 0, 0, 0, "R3 requester removed");

        // R10 stray response while idle
        @(negedge clk);
        rsp_valid = 1'b1;
        @(negedge clk);
        rsp_valid = 1'b0;
        check(err_stray == 1'b1, "R10 stray flag", err_stray, 1);
        check(pending_cnt == 0 && !busy, "R10 count stays zero", pending_cnt, 0);
        @(negedge clk);
        check(err_stray == 1'b0, "R10 flag is one cycle", err_stray, 0);

        // R10 stray response during an empty transaction's drain cycle
        begin
            int c;
            @(negedge clk);
            start_valid = 1'b1; start_kind = 2'b10; start_req_id = '0;
            cfg_cpu_only = 1'b1; cfg_accel_no_dir = 1'b1; start_conflict_free = 1'b0;
            c = tb_cyc;
            push_done(c + 2, c + 1, "R9 drain with stray");
            @(negedge clk);
            start_valid = 1'b0;
            rsp_valid = 1'b1;
            @(negedge clk);
            rsp_valid = 1'b0;
            check(err_stray == 1'b1, "R10 stray in drain", err_stray, 1);
            repeat (2) @(negedge clk);
        end

        // R11 start while busy is ignored
        begin
            int c;
            @(negedge clk);
            start_valid = 1'b1; start_kind = 2'b00; start_req_id = NODE_W'(8);
            start_addr = AW'(1) << LOFF; start_conflict_free = 1'b0;
            cfg_cpu_only = 1'b0; cfg_accel_no_dir = 1'b0;
            c = tb_cyc;
            begin
                exp_t e;
                e.is_done = 1'b0; e.due = c + 1; e.dest = exp_mask(2'b00, 8, 1, 0, 0, 0);
                e.cnt = 2; e.kind = 2'b00; e.ret = 1'b1; e.stamp = c; e.tag = "R11 first";
                sb_q.push_back(e);
            end
            @(negedge clk);
            start_kind = 2'b01; start_req_id = '0;
            @(negedge clk);
            start_valid = 1'b0;
            check(int'(pending_cnt) == 2 && busy, "R11 busy start ignored", pending_cnt, 2);
            check(probe_start_time == CW'(c), "R11 stamp untouched", probe_start_time, c);
            rsp_valid = 1'b1;
            @(negedge clk);
            push_done(tb_cyc + 1, tb_cyc, "R11 finish");
            @(negedge clk);
            rsp_valid = 1'b0;
            repeat (2) @(negedge clk);
        end

        // R11 reserved kind is ignored
        @(negedge clk);
        start_valid = 1'b1; start_kind = 2'b11;
        @(negedge clk);
        start_valid = 1'b0;
        check(!busy && !probe_valid, "R11 reserved kind", busy, 0);
        repeat (3) @(negedge clk);
        check(sb_q.size() == 0, "scoreboard drained", sb_q.size(), 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule